// File: doc/BRIEF.md
# Line-Coalescing Request Table

This block sits between a core's memory port and the first-level cache controller. It tracks outstanding requests by request ID and operation type only; data, coherence and the cache arrays live elsewhere. Requests are grouped by cache line. The first request to a line that has no entry allocates a line entry and is issued downstream. Later requests to the same line are queued behind it in arrival order and are not issued. The single downstream request for the line then completes for all of them.

Completions arrive as read or write completions for a line. A read completion retires queued read-class requests from the head of the line's queue. It stops at the first write-class request, which is issued downstream again and stays at the head. A write completion retires everything queued on the line. Each retired request appears on the done outputs, one per cycle. A locked read-modify-write read locks its line when it retires. Until a locked write retires, any other request to that line is turned away as aliased.

Top module: `csq_table`

## Requirements
- R1: A request is refused with status FULL (2) when the total number of outstanding requests is at or above MAX_OUT, unless `req_abort` is high, in which case the limit is not applied.
- R2: A request whose line already has an entry is appended to that line's queue and answered ALIASED (1). It produces no downstream issue.
- R3: A request whose line has no entry is answered READY (0). It takes a free entry and appears on the issue outputs in the following cycle, with its line and ID.
- R4: A read completion retires head entries of the line, in arrival order, while their op is a read class: load (0), instruction fetch (1) or load-linked (2).
- R5: During a read completion, the first write-class entry reached ends the drain and is issued downstream again one cycle later. It is not retired and stays at the head of the queue.
- R6: A write completion retires every entry queued on the line, whatever its op.
- R7: A line entry is released when its queue becomes empty. A later request to that line is then answered READY again.
- R8: When a locked read (op 6) retires, its line is locked. Requests to a locked line other than a locked write (op 7) are answered ALIASED and are not recorded. When a locked write retires, the lock is cleared.
- R9: Issue ops are mapped as follows: load-linked goes out as load (0); store-check read (5), locked read (6) and locked write (7) go out as store (3). Load, fetch, store, store-conditional (4) and flush (8) pass unchanged.
- R10: A request is refused with FULL when its line's queue already holds DEPTH entries, or when the line is new and no entry is free.
- R11: While a drain is running, `cpl_ready` is low and every request is refused with FULL. At most one entry retires per cycle.
- R12: A completion for a line with no entry is ignored: nothing retires and nothing is issued.
- R13: After reset, no entry is held, nothing is issued or retired, and `cpl_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | New request present this cycle |
| req_line | input | LINE_W | Cache line address of the request |
| req_id | input | ID_W | Request identifier |
| req_op | input | 4 | Request op code (0 load … 8 flush) |
| req_abort | input | 1 | Abort-class request, exempt from the outstanding limit |
| req_status | output | 2 | Same-cycle answer: 0 ready, 1 aliased, 2 full |
| cpl_valid | input | 1 | Completion present this cycle |
| cpl_write | input | 1 | 1 for a write completion, 0 for a read completion |
| cpl_line | input | LINE_W | Line the completion belongs to |
| cpl_ready | output | 1 | Completion can be taken (no drain running) |
| issue_valid | output | 1 | Downstream request valid |
| issue_line | output | LINE_W | Line of the downstream request |
| issue_id | output | ID_W | ID of the downstream request |
| issue_op | output | 4 | Mapped downstream op |
| done_valid | output | 1 | A queued request retires this cycle |
| done_id | output | ID_W | ID of the retiring request |
| done_op | output | 4 | Original op of the retiring request |

## Verification
The bench builds the table with two line entries, a queue depth of three and an outstanding limit of five. With these values the bench can reach, within a few requests, a full queue, the case where every entry is taken, and the outstanding limit, each on its own. An abort-class request above the limit can then be shown still being queued. The shallow queue is enough for a load, a load and a store on one line, so a read drain can be shown stopping at the store and reissuing it. The lock, the store-check mapping and the refusal of requests during a drain are each exercised on otherwise empty lines.

// File: rtl/csq_pkg.sv
`timescale 1ns/1ps
package csq_pkg;

   localparam logic [3:0] OP_LOAD   = 4'd0;
   localparam logic [3:0] OP_IFETCH = 4'd1;
   localparam logic [3:0] OP_LL     = 4'd2;
   localparam logic [3:0] OP_STORE  = 4'd3;
   localparam logic [3:0] OP_SC     = 4'd4;
   localparam logic [3:0] OP_RMWRD  = 4'd5;
   localparam logic [3:0] OP_LKRD   = 4'd6;
   localparam logic [3:0] OP_LKWR   = 4'd7;
   localparam logic [3:0] OP_FLUSH  = 4'd8;

   typedef enum logic [1:0] {
      ST_READY   = 2'd0,
      ST_ALIASED = 2'd1,
      ST_FULL    = 2'd2
   } csq_status_e;

   function automatic logic op_is_read(input logic [3:0] op);
      return (op == OP_LOAD) || (op == OP_IFETCH) || (op == OP_LL);
   endfunction

   function automatic logic [3:0] op_downstream(input logic [3:0] op);
      case (op)
         OP_LL:                      return OP_LOAD;
         OP_RMWRD, OP_LKRD, OP_LKWR: return OP_STORE;
         default:                    return op;
      endcase
   endfunction

endpackage

// File: rtl/csq_line.sv
`timescale 1ns/1ps
module csq_line #(
   parameter int ID_W   = 8,
   parameter int LINE_W = 26,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [LINE_W-1:0] push_tag,
   input  logic [ID_W-1:0]   push_id,
   input  logic [3:0]        push_op,
   input  logic              pop,
   output logic              occupied,
   output logic              last,
   output logic              full,
   output logic [LINE_W-1:0] tag,
   output logic [ID_W-1:0]   head_id,
   output logic [3:0]        head_op
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [ID_W-1:0] id_mem [DEPTH];
   logic [3:0]      op_mem [DEPTH];
   logic [PW-1:0]   wr_ptr, rd_ptr;
   logic [CW-1:0]   cnt;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         tag    <= '0;
      end else begin
         if (push) begin
            wr_ptr <= bump(wr_ptr);
            if (cnt == '0) tag <= push_tag;
         end
         if (pop) rd_ptr <= bump(rd_ptr);
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         id_mem[wr_ptr] <= push_id;
         op_mem[wr_ptr] <= push_op;
      end
   end

   assign occupied = (cnt != '0);
   assign last     = (cnt == CW'(1));
   assign full     = (cnt == CW'(DEPTH));
   assign head_id  = id_mem[rd_ptr];
   assign head_op  = op_mem[rd_ptr];
endmodule

// File: rtl/csq_find.sv
`timescale 1ns/1ps
module csq_find #(
   parameter int N      = 8,
   parameter int LINE_W = 26,
   parameter int IW     = 3
) (
   input  logic [N-1:0]        occ,
   input  logic [N*LINE_W-1:0] tags,
   input  logic [LINE_W-1:0]   key,
   output logic                hit,
   output logic [IW-1:0]       idx
);
   logic [N-1:0] match;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = occ[g] && (tags[g*LINE_W +: LINE_W] == key);
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match[i]) idx = IW'(i);
      end
   end

   assign hit = |match;
endmodule

// File: rtl/csq_table.sv
`timescale 1ns/1ps
module csq_table #(
   parameter int LINE_W  = 26,
   parameter int ID_W    = 8,
   parameter int NLINES  = 8,
   parameter int DEPTH   = 4,
   parameter int MAX_OUT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [LINE_W-1:0] req_line,
   input  logic [ID_W-1:0]   req_id,
   input  logic [3:0]        req_op,
   input  logic              req_abort,
   output logic [1:0]        req_status,
   input  logic              cpl_valid,
   input  logic              cpl_write,
   input  logic [LINE_W-1:0] cpl_line,
   output logic              cpl_ready,
   output logic              issue_valid,
   output logic [LINE_W-1:0] issue_line,
   output logic [ID_W-1:0]   issue_id,
   output logic [3:0]        issue_op,
   output logic              done_valid,
   output logic [ID_W-1:0]   done_id,
   output logic [3:0]        done_op
);
   import csq_pkg::*;

   localparam int IW  = (NLINES > 1) ? $clog2(NLINES) : 1;
   localparam int CAP = NLINES * DEPTH;
   localparam int OW  = $clog2(CAP + 1);
   localparam logic [OW-1:0] MAX_V = OW'(MAX_OUT);

   if (NLINES < 1) begin : g_bad_lines
      $error("csq_table: NLINES must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("csq_table: DEPTH must be at least 2");
   end
   if (MAX_OUT < 1 || MAX_OUT > CAP) begin : g_bad_max
      $error("csq_table: MAX_OUT must lie in 1..NLINES*DEPTH");
   end

   // per-line storage
   logic [NLINES-1:0]        occ_v, last_v, full_v, push_vec, pop_vec;
   logic [NLINES*LINE_W-1:0] tag_flat;
   logic [ID_W-1:0]          hd_id [NLINES];
   logic [3:0]               hd_op [NLINES];

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      csq_line #(.ID_W(ID_W), .LINE_W(LINE_W), .DEPTH(DEPTH)) u_line (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (push_vec[g]),
         .push_tag (req_line),
         .push_id  (req_id),
         .push_op  (req_op),
         .pop      (pop_vec[g]),
         .occupied (occ_v[g]),
         .last     (last_v[g]),
         .full     (full_v[g]),
         .tag      (tag_flat[g*LINE_W +: LINE_W]),
         .head_id  (hd_id[g]),
         .head_op  (hd_op[g])
      );
   end

   // lookups for the request line and the completion line
   logic          rq_hit, cq_hit;
   logic [IW-1:0] rq_idx, cq_idx;

   csq_find #(.N(NLINES), .LINE_W(LINE_W), .IW(IW)) u_req_find (
      .occ(occ_v), .tags(tag_flat), .key(req_line), .hit(rq_hit), .idx(rq_idx));
   csq_find #(.N(NLINES), .LINE_W(LINE_W), .IW(IW)) u_cpl_find (
      .occ(occ_v), .tags(tag_flat), .key(cpl_line), .hit(cq_hit), .idx(cq_idx));

   logic          free_ok;
   logic [IW-1:0] free_idx;
   always_comb begin
      free_idx = '0;
      for (int i = NLINES - 1; i >= 0; i--) begin
         if (!occ_v[i]) free_idx = IW'(i);
      end
   end
   assign free_ok = ~&occ_v;

   // state
   logic              busy_q, drn_write_q;
   logic [IW-1:0]     drn_idx_q;
   logic              lock_vld_q;
   logic [LINE_W-1:0] lock_tag_q;
   logic [OW-1:0]     out_cnt_q;

   // request admission
   csq_status_e st;
   logic        new_iss;
   always_comb begin
      st       = ST_READY;
      push_vec = '0;
      new_iss  = 1'b0;
      if (req_valid) begin
         if (busy_q) begin
            st = ST_FULL;
         end else if (out_cnt_q >= MAX_V && !req_abort) begin
            st = ST_FULL;
         end else if (lock_vld_q && lock_tag_q == req_line && req_op != OP_LKWR) begin
            st = ST_ALIASED;
         end else if (rq_hit) begin
            if (full_v[rq_idx]) begin
               st = ST_FULL;
            end else begin
               st = ST_ALIASED;
               push_vec[rq_idx] = 1'b1;
            end
         end else if (!free_ok) begin
            st = ST_FULL;
         end else begin
            st = ST_READY;
            push_vec[free_idx] = 1'b1;
            new_iss = 1'b1;
         end
      end
   end
   assign req_status = st;

   // drain engine
   logic       done_v, reiss, drn_end;
   logic [3:0] cur_op;
   assign cur_op = hd_op[drn_idx_q];

   always_comb begin
      pop_vec = '0;
      done_v  = 1'b0;
      reiss   = 1'b0;
      drn_end = 1'b0;
      if (busy_q) begin
         if (drn_write_q || op_is_read(cur_op)) begin
            pop_vec[drn_idx_q] = 1'b1;
            done_v  = 1'b1;
            drn_end = last_v[drn_idx_q];
         end else begin
            reiss   = 1'b1;
            drn_end = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         drn_write_q <= 1'b0;
         drn_idx_q   <= '0;
         lock_vld_q  <= 1'b0;
         lock_tag_q  <= '0;
         out_cnt_q   <= '0;
         issue_valid <= 1'b0;
         issue_line  <= '0;
         issue_id    <= '0;
         issue_op    <= '0;
      end else begin
         if (busy_q) begin
            if (drn_end) busy_q <= 1'b0;
         end else if (cpl_valid && cq_hit) begin
            busy_q      <= 1'b1;
            drn_idx_q   <= cq_idx;
            drn_write_q <= cpl_write;
         end

         issue_valid <= new_iss | reiss;
         if (new_iss) begin
            issue_line <= req_line;
            issue_id   <= req_id;
            issue_op   <= op_downstream(req_op);
         end else if (reiss) begin
            issue_line <= tag_flat[drn_idx_q*LINE_W +: LINE_W];
            issue_id   <= hd_id[drn_idx_q];
            issue_op   <= op_downstream(cur_op);
         end

         if (done_v && drn_write_q) begin
            if (cur_op == OP_LKRD) begin
               lock_vld_q <= 1'b1;
               lock_tag_q <= tag_flat[drn_idx_q*LINE_W +: LINE_W];
            end else if (cur_op == OP_LKWR) begin
               lock_vld_q <= 1'b0;
            end
         end

         out_cnt_q <= out_cnt_q + OW'(|push_vec) - OW'(done_v);
      end
   end

   assign cpl_ready  = !busy_q;
   assign done_valid = done_v;
   assign done_id    = hd_id[drn_idx_q];
   assign done_op    = cur_op;
endmodule

// File: rtl/csq_chk.sv
`timescale 1ns/1ps
module csq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_status,
   input logic       cpl_ready,
   input logic       issue_valid,
   input logic [3:0] issue_op,
   input logic       done_valid,
   input logic [3:0] done_op,
   input logic       drn_write
);
   // R3
   ready_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_status == 2'd0) |=> issue_valid);

   // R2
   alias_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_status == 2'd1) |=> !issue_valid);

   // R9
   issue_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (issue_op == 4'd0 || issue_op == 4'd1 || issue_op == 4'd3 ||
                       issue_op == 4'd4 || issue_op == 4'd8));

   // R4
   read_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !drn_write) |-> (done_op <= 4'd2));

   // R11
   drain_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> !cpl_ready);

   // R11
   busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !cpl_ready) |-> (req_status == 2'd2));
endmodule

bind csq_table csq_chk u_csq_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_status  (req_status),
   .cpl_ready   (cpl_ready),
   .issue_valid (issue_valid),
   .issue_op    (issue_op),
   .done_valid  (done_valid),
   .done_op     (done_op),
   .drn_write   (drn_write_q)
);

// File: tb/test_csq_table.sv
`timescale 1ns/1ps
module test_csq_table;
   localparam int LINE_W = 16;
   localparam int ID_W   = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_abort = 1'b0, cpl_valid = 1'b0, cpl_write = 1'b0;
   logic [LINE_W-1:0] req_line = '0, cpl_line = '0;
   logic [ID_W-1:0]   req_id = '0;
   logic [3:0]        req_op = '0;
   logic [1:0]        req_status;
   logic              cpl_ready, issue_valid, done_valid;
   logic [LINE_W-1:0] issue_line;
   logic [ID_W-1:0]   issue_id, done_id;
   logic [3:0]        issue_op, done_op;

   int checks = 0;
   int errors = 0;
   logic [LINE_W+ID_W+3:0] exp_iss [$];
   logic [ID_W+3:0]        exp_done [$];

   always #2 clk = ~clk;

   csq_table #(.LINE_W(LINE_W), .ID_W(ID_W), .NLINES(2), .DEPTH(3), .MAX_OUT(5)) i_csq_table (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_line(req_line), .req_id(req_id), .req_op(req_op),
      .req_abort(req_abort), .req_status(req_status),
      .cpl_valid(cpl_valid), .cpl_write(cpl_write), .cpl_line(cpl_line), .cpl_ready(cpl_ready),
      .issue_valid(issue_valid), .issue_line(issue_line), .issue_id(issue_id), .issue_op(issue_op),
      .done_valid(done_valid), .done_id(done_id), .done_op(done_op));

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   task automatic want_issue(input int line, input int id, input int op);
      exp_iss.push_back({LINE_W'(line), ID_W'(id), 4'(op)});
   endtask

   task automatic want_done(input int id, input int op);
      exp_done.push_back({ID_W'(id), 4'(op)});
   endtask

   task automatic send(input int line, input int id, input int op, input bit abort,
                       input int exp_st, input string rq);
      @(negedge clk);
      req_valid = 1'b1; req_line = LINE_W'(line); req_id = ID_W'(id);
      req_op = 4'(op); req_abort = abort;
      #1;
      chk(req_status == 2'(exp_st), rq, "status", req_status, exp_st);
      @(posedge clk);
      #1;
      req_valid = 1'b0; req_abort = 1'b0;
   endtask

   task automatic idle_wait();
      forever begin
         @(negedge clk);
         if (cpl_ready) break;
      end
   endtask

   task automatic complete(input int line, input bit wr);
      @(negedge clk);
      cpl_valid = 1'b1; cpl_write = wr; cpl_line = LINE_W'(line);
      @(posedge clk);
      #1;
      cpl_valid = 1'b0;
      idle_wait();
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (issue_valid) begin
            if (exp_iss.size() == 0) begin
               chk(1'b0, "R2", "unexpected issue id", int'(issue_id), -1);
            end else begin
               logic [LINE_W+ID_W+3:0] e;
               e = exp_iss.pop_front();
               chk({issue_line, issue_id, issue_op} == e, "R3/R5/R9", "issue {line,id,op}",
                   int'({issue_line, issue_id, issue_op}), int'(e));
            end
         end
         if (done_valid) begin
            if (exp_done.size() == 0) begin
               chk(1'b0, "R12", "unexpected done id", int'(done_id), -1);
            end else begin
               logic [ID_W+3:0] e;
               e = exp_done.pop_front();
               chk({done_id, done_op} == e, "R4/R6", "done {id,op}",
                   int'({done_id, done_op}), int'(e));
            end
         end
      end
   end

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk(!issue_valid, "R13", "issue_valid", issue_valid, 0);
      chk(!done_valid, "R13", "done_valid", done_valid, 0);
      chk(cpl_ready, "R13", "cpl_ready", cpl_ready, 1);

      // R3 R9: load-linked goes out as load
      want_issue('h10, 1, 0);
      send('h10, 1, 2, 0, 0, "R3");
      send('h10, 2, 0, 0, 1, "R2");
      send('h10, 3, 3, 0, 1, "R2");
      send('h10, 4, 0, 0, 2, "R10 queue full");
      want_issue('h20, 5, 1);
      send('h20, 5, 1, 0, 0, "R3");
      send('h30, 6, 0, 0, 2, "R10 no free entry");
      send('h20, 7, 0, 0, 1, "R2");
      send('h20, 19, 0, 0, 2, "R1 limit");
      send('h20, 20, 0, 1, 1, "R1 abort bypass");

      // R4 R5: read drain stops at the store and reissues it
      want_done(1, 2); want_done(2, 0);
      want_issue('h10, 3, 3);
      complete('h10, 0);
      // R6: write completion retires the store left at the head
      want_done(3, 3);
      complete('h10, 1);
      want_done(5, 1); want_done(7, 0); want_done(20, 0);
      complete('h20, 0);

      // R7: released line is fresh again
      want_issue('h10, 8, 8);
      send('h10, 8, 8, 0, 0, "R7");
      want_done(8, 8);
      complete('h10, 1);

      // R8: lock
      want_issue('h40, 9, 3);
      send('h40, 9, 6, 0, 0, "R9 locked read as store");
      want_done(9, 6);
      complete('h40, 1);
      send('h40, 10, 0, 0, 1, "R8 blocked");
      want_issue('h40, 11, 3);
      send('h40, 11, 7, 0, 0, "R8 locked write passes");
      want_done(11, 7);
      complete('h40, 1);
      want_issue('h40, 12, 0);
      send('h40, 12, 0, 0, 0, "R8 unlocked");
      want_done(12, 0);
      complete('h40, 0);

      // R9 store-check read, R6 write drain covers reads
      want_issue('h50, 13, 3);
      send('h50, 13, 5, 0, 0, "R9 store-check");
      send('h50, 14, 0, 0, 1, "R2");
      want_done(13, 5); want_done(14, 0);
      complete('h50, 1);

      want_issue('h60, 15, 4);
      send('h60, 15, 4, 0, 0, "R9 store-conditional");
      want_done(15, 4);
      complete('h60, 1);

      // R12 completion for unknown line
      complete('h99, 0);
      complete('h99, 1);

      // R11 request during a drain is refused
      want_issue('h70, 16, 0);
      send('h70, 16, 0, 0, 0, "R3");
      send('h70, 17, 0, 0, 1, "R2");
      send('h70, 18, 1, 0, 1, "R2");
      want_done(16, 0); want_done(17, 0); want_done(18, 1);
      @(negedge clk);
      cpl_valid = 1'b1; cpl_write = 1'b0; cpl_line = 'h70;
      @(posedge clk);
      #1 cpl_valid = 1'b0;
      @(negedge clk);
      chk(!cpl_ready, "R11", "cpl_ready during drain", cpl_ready, 0);
      req_valid = 1'b1; req_line = 'h80; req_id = 21; req_op = 0;
      #1;
      chk(req_status == 2'd2, "R11", "status during drain", req_status, 2);
      @(posedge clk);
      #1 req_valid = 1'b0;
      idle_wait();

      repeat (4) @(negedge clk);
      chk(exp_iss.size() == 0, "R3", "pending issues", exp_iss.size(), 0);
      chk(exp_done.size() == 0, "R6", "pending retires", exp_done.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule